// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block visits every configuration frame of a programmable device region, one word at a time, so that a configuration-port controller can read back or rewrite the region. The visit order has four nested levels. The device half is the outermost: the top half first, then the bottom half. Inside each half come the three block types in turn. Inside each block type the major columns run from left to right. Inside each column the minor frames run upward from 0. Each frame is 41 words of 32 bits. Top-half frames are presented from word 40 down to word 0. Bottom-half frames are presented from word 0 up to word 40.

The number of minor frames in a major column depends on the column's class. Inside the mixed logic block type, the class comes from a built-in 48-column map. The two memory block types use 8 columns each, and those columns have fixed minor counts. With each word the block presents a 32-bit guard mask. The mask marks the bit positions of memory-content frames that do not accept a written 1, so the controller can keep them clear. A start pulse begins a walk and a one-cycle done pulse ends it. A pause input suspends the offer of words, and a ready input accepts them.

Top module: `cfg_frame_walker`

## Requirements
- R1: While reset is low, and after it is released, `busy_o`, `valid_o` and `done_o` are all 0.
- R2: A `start_i` pulse while idle makes the first offered word half 0 (top), block type 0, major 0, minor 0, word index 40. `frame_addr_o` is packed as half in bit 14, block type in bits 13:12 (0 mixed logic, 1 memory interconnect, 2 memory content), major column in bits 11:6 and minor frame in bits 5:0.
- R3: In block type 0 the minor count is 30 for columns 0, 23 and 47, 3 for column 24, 21 for columns 7, 16, 31 and 40, and 22 for every other column in the range 0 to 47.
- R4: Block type 1 spans columns 0 to 7 with 20 minors each. Block type 2 spans columns 0 to 7 with 64 minors each.
- R5: In the top half, `word_idx_o` counts 40 down to 0 and `word_down_o` is 1. In the bottom half, it counts 0 up to 40 and `word_down_o` is 0.
- R6: While `valid_o` is 1 and `ready_i` is 0, the address and word index hold.
- R7: While `pause_i` is 1, `valid_o` is 0 and the position holds.
- R8: A word is accepted when `valid_o` and `ready_i` are both 1. The address changes only when the last word of a frame is accepted. Minor advances first, then major, then block type, then half.
- R9: In block type 2, `guard_mask_o` has exactly one bit set on these words: in the top half, words 4, 14, 25 and 35 at bit 8; in the bottom half, words 5, 15, 26 and 36 at bit 24. Every other word of every frame has a mask of 0.
- R10: The cycle after the last word of the bottom-half block-type-2 walk is accepted, `done_o` is 1 for exactly one cycle, and `busy_o` and `valid_o` are 0.
- R11: A `start_i` pulse while busy is ignored, and the walk continues from its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk when idle |
| pause_i | input | 1 | Suspend offering words |
| ready_i | input | 1 | Consumer accepts the offered word |
| busy_o | output | 1 | A walk is in progress |
| valid_o | output | 1 | A word position is offered |
| frame_addr_o | output | 15 | Packed {half, block type, major, minor} |
| word_idx_o | output | 6 | Word index inside the frame, 0..40 |
| word_down_o | output | 1 | 1 when the frame is walked from word 40 downward |
| guard_mask_o | output | 32 | Bits of this word that must not be written as 1 |
| done_o | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The bench targets the column boundaries where the minor count changes, such as the single clock column and the I/O columns at the map edges. A wrong map there would skip frames or repeat them, and the address stream would drift away from the model. It targets the half boundary, where the word order flips. An error there would give bottom frames in descending order or would shift the guard bits by one word. It stalls with ready low and with pause high on last words of frames, where a design that advanced anyway would lose a frame. It also checks the done pulse and a start pulse sent during a walk; a wrong design would repeat done or restart from column 0.

// File: rtl/cfw_pkg.sv
// Shared types and constants of the frame address sequencer.
// Assumes a frame of 41 words of 32 bits for the guard offsets.
package cfw_pkg;
    typedef enum logic [1:0] {
        BLK_MIX  = 2'd0,
        BLK_BINT = 2'd1,
        BLK_BDAT = 2'd2
    } blk_e;

    typedef enum logic [1:0] {
        COL_LOGIC = 2'd0,
        COL_DSP   = 2'd1,
        COL_IO    = 2'd2,
        COL_CLK   = 2'd3
    } col_e;

    localparam int GUARD_CNT = 4;
    // frame bit offsets counted from word 0, bit 0
    localparam int GUARD_TOP [GUARD_CNT] = '{136, 456, 808, 1128};
    localparam int GUARD_BOT [GUARD_CNT] = '{184, 504, 856, 1176};
endpackage

// File: rtl/cfw_column_map.sv
// Column map: gives the last minor index of the current major column
// and the last major index of the current block type.
// Assumes the mixed block map is mirror-symmetric about its centre.
module cfw_column_map
    import cfw_pkg::*;
#(
    parameter int MAJ_W        = 6,
    parameter int MIN_W        = 6,
    parameter int MIX_COLS     = 48,
    parameter int BRAM_COLS    = 8,
    parameter int DSP_POS_A    = 7,
    parameter int DSP_POS_B    = 16,
    parameter int LOGIC_MINORS = 22,
    parameter int DSP_MINORS   = 21,
    parameter int IO_MINORS    = 30,
    parameter int CLK_MINORS   = 3,
    parameter int BINT_MINORS  = 20,
    parameter int BDAT_MINORS  = 64
) (
    input  blk_e             blk_i,
    input  logic [MAJ_W-1:0] major_i,
    output logic [MIN_W-1:0] minor_last_o,
    output logic [MAJ_W-1:0] major_last_o
);
    localparam int IO_MID  = MIX_COLS / 2 - 1;
    localparam int CLK_POS = MIX_COLS / 2;
    localparam int DSP_C   = MIX_COLS - 1 - DSP_POS_B;
    localparam int DSP_D   = MIX_COLS - 1 - DSP_POS_A;

    col_e cls;

    // classify the column within the mixed logic map
    always_comb begin
        if (major_i == MAJ_W'(0) || major_i == MAJ_W'(IO_MID) ||
            major_i == MAJ_W'(MIX_COLS - 1))
            cls = COL_IO;
        else if (major_i == MAJ_W'(CLK_POS))
            cls = COL_CLK;
        else if (major_i == MAJ_W'(DSP_POS_A) || major_i == MAJ_W'(DSP_POS_B) ||
                 major_i == MAJ_W'(DSP_C) || major_i == MAJ_W'(DSP_D))
            cls = COL_DSP;
        else
            cls = COL_LOGIC;
    end

    // pick the last minor index from block type and column class
    always_comb begin
        case (blk_i)
            BLK_MIX: begin
                case (cls)
                    COL_IO:  minor_last_o = MIN_W'(IO_MINORS - 1);
                    COL_CLK: minor_last_o = MIN_W'(CLK_MINORS - 1);
                    COL_DSP: minor_last_o = MIN_W'(DSP_MINORS - 1);
                    default: minor_last_o = MIN_W'(LOGIC_MINORS - 1);
                endcase
            end
            BLK_BINT: minor_last_o = MIN_W'(BINT_MINORS - 1);
            default:  minor_last_o = MIN_W'(BDAT_MINORS - 1);
        endcase
    end

    // pick the last major index of the block type
    always_comb begin
        major_last_o = (blk_i == BLK_MIX) ? MAJ_W'(MIX_COLS - 1) : MAJ_W'(BRAM_COLS - 1);
    end
endmodule

// File: rtl/cfw_beat_ctr.sv
// Word beat counter: counts accepted words 0..FRAME_WORDS-1 within a
// frame and maps the beat to a word index according to the direction.
// Assumes adv_i is only raised for an accepted word.
module cfw_beat_ctr #(
    parameter int FRAME_WORDS = 41,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic             down_i,
    output logic [IDX_W-1:0] word_idx_o,
    output logic             last_o
);
    logic [IDX_W-1:0] beat_q;

    // flag the final beat of the frame
    always_comb last_o = (beat_q == IDX_W'(FRAME_WORDS - 1));

    // present the word index in the chosen direction
    always_comb word_idx_o = down_i ? (IDX_W'(FRAME_WORDS - 1) - beat_q) : beat_q;

    // step the beat on each accepted word, wrap at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (clr_i)  beat_q <= '0;
        else if (adv_i)  beat_q <= last_o ? '0 : beat_q + 1'b1;
    end

    p_beat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_idx_o < IDX_W'(FRAME_WORDS))
        else $error("word index out of frame");
endmodule

// File: rtl/cfw_frame_walk.sv
// Frame position walker: holds half, block type, major and minor, and
// steps them in nested order when a frame completes.
// Assumes the limits come from the column map of the current position.
module cfw_frame_walk
    import cfw_pkg::*;
#(
    parameter int MAJ_W = 6,
    parameter int MIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [MIN_W-1:0] minor_last_i,
    input  logic [MAJ_W-1:0] major_last_i,
    output logic             half_o,
    output blk_e             blk_o,
    output logic [MAJ_W-1:0] major_o,
    output logic [MIN_W-1:0] minor_o,
    output logic             final_o
);
    logic             half_q;
    blk_e             blk_q;
    logic [MAJ_W-1:0] major_q;
    logic [MIN_W-1:0] minor_q;

    logic minor_end, major_end, blk_end;

    // detect the wrap of each nesting level
    always_comb begin
        minor_end = (minor_q == minor_last_i);
        major_end = minor_end && (major_q == major_last_i);
        blk_end   = major_end && (blk_q == BLK_BDAT);
        final_o   = blk_end && half_q;
    end

    // advance the nested position at the end of a frame
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            half_q  <= 1'b0;
            blk_q   <= BLK_MIX;
            major_q <= '0;
            minor_q <= '0;
        end else if (adv_i) begin
            minor_q <= minor_end ? '0 : minor_q + 1'b1;
            if (minor_end) major_q <= major_end ? '0 : major_q + 1'b1;
            if (major_end) begin
                case (blk_q)
                    BLK_MIX:  blk_q <= BLK_BINT;
                    BLK_BINT: blk_q <= BLK_BDAT;
                    default:  blk_q <= BLK_MIX;
                endcase
            end
            if (blk_end) half_q <= ~half_q;
        end
    end

    // expose the position
    always_comb begin
        half_o  = half_q;
        blk_o   = blk_q;
        major_o = major_q;
        minor_o = minor_q;
    end

    p_minor_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        minor_q <= minor_last_i)
        else $error("minor beyond column count");

    p_major_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        major_q <= major_last_i)
        else $error("major beyond block width");
endmodule

// File: rtl/cfw_guard_mask.sv
// Guard mask: marks the bits of the current word that must stay 0 when
// memory-content frames are written.
// Assumes the offsets are counted from word 0 in both halves.
module cfw_guard_mask
    import cfw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 6
) (
    input  blk_e              blk_i,
    input  logic              half_i,
    input  logic [IDX_W-1:0]  word_idx_i,
    output logic [WORD_W-1:0] mask_o
);
    localparam int BIT_W = $clog2(WORD_W);

    // set the bit of any guarded offset that falls in this word
    always_comb begin
        int off;
        mask_o = '0;
        off    = 0;
        if (blk_i == BLK_BDAT) begin
            for (int g = 0; g < GUARD_CNT; g++) begin
                off = half_i ? GUARD_BOT[g] : GUARD_TOP[g];
                if ((off / WORD_W) == int'(word_idx_i))
                    mask_o[BIT_W'(off % WORD_W)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_frame_walker.sv
// Top of the frame address sequencer: runs the walk on a start pulse,
// offers one word position per cycle under ready/pause and pulses done.
// Assumes the consumer samples outputs whenever valid_o and ready_i meet.
module cfg_frame_walker
    import cfw_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int FRAME_WORDS  = 41,
    parameter int MAJ_W        = 6,
    parameter int MIN_W        = 6,
    parameter int MIX_COLS     = 48,
    parameter int BRAM_COLS    = 8,
    parameter int DSP_POS_A    = 7,
    parameter int DSP_POS_B    = 16,
    parameter int LOGIC_MINORS = 22,
    parameter int DSP_MINORS   = 21,
    parameter int IO_MINORS    = 30,
    parameter int CLK_MINORS   = 3,
    parameter int BINT_MINORS  = 20,
    parameter int BDAT_MINORS  = 64,
    localparam int IDX_W       = $clog2(FRAME_WORDS),
    localparam int ADDR_W      = 3 + MAJ_W + MIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pause_i,
    input  logic              ready_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] frame_addr_o,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic              word_down_o,
    output logic [WORD_W-1:0] guard_mask_o,
    output logic              done_o
);
    logic             run_q, done_q;
    logic             hs, launch, beat_last, frame_end, walk_final, run_end;
    logic             half;
    blk_e             blk;
    logic [MAJ_W-1:0] major, major_last;
    logic [MIN_W-1:0] minor, minor_last;

    // handshake and control events
    always_comb begin
        valid_o   = run_q & ~pause_i;
        hs        = valid_o & ready_i;
        launch    = start_i & ~run_q;
        frame_end = hs & beat_last;
        run_end   = frame_end & walk_final;
    end

    // run state and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= run_end;
            if (launch)       run_q <= 1'b1;
            else if (run_end) run_q <= 1'b0;
        end
    end

    cfw_column_map #(
        .MAJ_W(MAJ_W), .MIN_W(MIN_W), .MIX_COLS(MIX_COLS), .BRAM_COLS(BRAM_COLS),
        .DSP_POS_A(DSP_POS_A), .DSP_POS_B(DSP_POS_B),
        .LOGIC_MINORS(LOGIC_MINORS), .DSP_MINORS(DSP_MINORS), .IO_MINORS(IO_MINORS),
        .CLK_MINORS(CLK_MINORS), .BINT_MINORS(BINT_MINORS), .BDAT_MINORS(BDAT_MINORS)
    ) u_map (
        .blk_i(blk), .major_i(major),
        .minor_last_o(minor_last), .major_last_o(major_last)
    );

    cfw_frame_walk #(.MAJ_W(MAJ_W), .MIN_W(MIN_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr_i(launch), .adv_i(frame_end),
        .minor_last_i(minor_last), .major_last_i(major_last),
        .half_o(half), .blk_o(blk), .major_o(major), .minor_o(minor),
        .final_o(walk_final)
    );

    cfw_beat_ctr #(.FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)) u_beat (
        .clk(clk), .rst_n(rst_n), .clr_i(launch), .adv_i(hs), .down_i(~half),
        .word_idx_o(word_idx_o), .last_o(beat_last)
    );

    cfw_guard_mask #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_guard (
        .blk_i(blk), .half_i(half), .word_idx_i(word_idx_o), .mask_o(guard_mask_o)
    );

    // drive the remaining outputs
    always_comb begin
        busy_o       = run_q;
        done_o       = done_q;
        word_down_o  = ~half;
        frame_addr_o = {half, blk, major, minor};
    end

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> ($stable(frame_addr_o) && $stable(word_idx_o)))
        else $error("position moved during stall");

    p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pause_i) |=> ($stable(frame_addr_o) && $stable(word_idx_o)))
        else $error("position moved during pause");

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !beat_last) |=> $stable(frame_addr_o))
        else $error("address moved mid-frame");

    p_mask_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($countones(guard_mask_o) <= 1))
        else $error("more than one guard bit in a word");

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o)
        else $error("done while busy");

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !hs) |=> $stable(frame_addr_o))
        else $error("start restarted a running walk");
endmodule

// File: tb/cfg_frame_walker_test.sv
module cfg_frame_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 195000;

    logic        clk = 1'b0;
    logic        rst_n, start_i, pause_i, ready_i;
    logic        busy_o, valid_o, word_down_o, done_o;
    logic [14:0] frame_addr_o;
    logic [5:0]  word_idx_o;
    logic [31:0] guard_mask_o;

    int total = 0;
    int bad   = 0;

    int m_half, m_blk, m_maj, m_min, m_beat;
    bit m_run, m_done;
    bit f_first, f_busy_start, f_stall, f_pause, f_frame;
    int mask_hits;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_frame_walker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pause_i(pause_i),
        .ready_i(ready_i), .busy_o(busy_o), .valid_o(valid_o),
        .frame_addr_o(frame_addr_o), .word_idx_o(word_idx_o),
        .word_down_o(word_down_o), .guard_mask_o(guard_mask_o), .done_o(done_o)
    );

    function automatic int f_minors(int blk, int maj);
        if (blk == 1) return 20;
        if (blk == 2) return 64;
        if (maj == 0 || maj == 23 || maj == 47) return 30;
        if (maj == 24) return 3;
        if (maj == 7 || maj == 16 || maj == 31 || maj == 40) return 21;
        return 22;
    endfunction

    function automatic int f_majors(int blk);
        return (blk == 0) ? 48 : 8;
    endfunction

    function automatic logic [31:0] f_mask(int half, int blk, int word);
        logic [31:0] m;
        int offs [4];
        m = '0;
        if (blk != 2) return m;
        if (half == 0) offs = '{136, 456, 808, 1128};
        else           offs = '{184, 504, 856, 1176};
        for (int g = 0; g < 4; g++)
            if (offs[g] / 32 == word) m[offs[g] % 32] = 1'b1;
        return m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_home();
        m_half = 0; m_blk = 0; m_maj = 0; m_min = 0; m_beat = 0;
    endtask

    task automatic model_adv(output bit frame_done);
        frame_done = 0;
        m_beat++;
        if (m_beat == 41) begin
            frame_done = 1;
            m_beat = 0;
            m_min++;
            if (m_min == f_minors(m_blk, m_maj)) begin
                m_min = 0;
                m_maj++;
                if (m_maj == f_majors(m_blk)) begin
                    m_maj = 0;
                    m_blk++;
                    if (m_blk == 3) begin
                        m_blk = 0;
                        if (m_half == 1) begin
                            m_half = 0;
                            m_run  = 0;
                            m_done = 1;
                        end else m_half = 1;
                    end
                end
            end
        end
    endtask

    // one cycle: check at the negedge, drive, then cross the posedge
    task automatic cycle(input bit rdy, input bit pse, input bit st);
        bit hs, fd;
        string tag;
        logic [14:0] ea;
        logic [31:0] em;
        check("R10 done", 32'(done_o), 32'(m_done));
        check("R10 busy", 32'(busy_o), 32'(m_run));
        check("R7 valid", 32'(valid_o), 32'(m_run && !pause_i));
        if (m_run) begin
            if (f_first)           tag = "R2 addr";
            else if (f_busy_start) tag = "R11 addr";
            else if (f_stall)      tag = "R6 addr";
            else if (f_pause)      tag = "R7 addr";
            else if (f_frame)      tag = "R8 addr";
            else if (m_blk == 0)   tag = "R3 addr";
            else                   tag = "R4 addr";
            ea = {1'(m_half), 2'(m_blk), 6'(m_maj), 6'(m_min)};
            check(tag, 32'(frame_addr_o), 32'(ea));
            check("R5 word", 32'(word_idx_o), (m_half == 0) ? 32'(40 - m_beat) : 32'(m_beat));
            check("R5 dir", 32'(word_down_o), 32'(m_half == 0));
            em = f_mask(m_half, m_blk, (m_half == 0) ? 40 - m_beat : m_beat);
            check("R9 mask", guard_mask_o, em);
            if (valid_o && em != 0) mask_hits++;
        end
        m_done = 0;
        ready_i = rdy; pause_i = pse; start_i = st;
        #1;
        hs = valid_o && ready_i;
        f_first      = 0;
        f_busy_start = st && m_run;
        f_stall      = m_run && valid_o && !ready_i;
        f_pause      = m_run && pse;
        @(posedge clk);
        fd = 0;
        if (hs) model_adv(fd);
        f_frame = fd;
        if (st && !m_run && !hs && !m_done) begin
            m_run = 1;
            model_home();
            f_first = 1;
        end
        @(negedge clk);
        start_i = 0;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        rst_n = 0; start_i = 0; pause_i = 0; ready_i = 0;
        m_run = 0; m_done = 0; model_home();
        f_first = 0; f_busy_start = 0; f_stall = 0; f_pause = 0; f_frame = 0;
        mask_hits = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 busy", 32'(busy_o), 0);
        check("R1 valid", 32'(valid_o), 0);
        check("R1 done", 32'(done_o), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle after release", 32'(busy_o), 0);

        // run A: random ready and pause, directed stalls, start while busy
        cycle(1, 0, 1);
        for (int i = 0; i < 3000; i++) begin
            bit rdy, pse;
            rdy = ($urandom % 4) != 0;
            pse = ($urandom % 10) == 0;
            if (i >= 100 && i < 104) begin rdy = 0; pse = 0; end
            if (i >= 200 && i < 203) begin rdy = 1; pse = 1; end
            cycle(rdy, pse, i == 1500);
        end

        // R1: reset mid-walk returns to idle
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1 busy after reset", 32'(busy_o), 0);
        check("R1 valid after reset", 32'(valid_o), 0);
        rst_n = 1;
        m_run = 0; m_done = 0; model_home();
        f_busy_start = 0; f_stall = 0; f_pause = 0; f_frame = 0;

        // run B: full walk at full rate
        mask_hits = 0;
        cycle(1, 0, 1);
        for (int n = 0; n < 150000 && m_run; n++) cycle(1, 0, 0);
        cycle(1, 0, 0);
        cycle(1, 0, 0);
        check("R9 guarded word count", 32'(mask_hits), 32'd4096);
        check("R10 idle at end", 32'(busy_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule